// File: doc/BRIEF.md
# Ordered Test Pattern Sequencer

The sequencer keeps a small bank of 32-bit test words and plays them out one at a time on a stimulus stream. The order of play is set by a separate table of bank indices. Its purpose is to measure how much switching a chosen order causes at the inputs of a circuit under test. Each accepted word is compared with the word accepted just before it. The number of bit positions that differ is added to a running transition count. When the last table slot has been played, the block raises a completion flag and holds the final count, so that two orders can be compared for test power.

Software-free loading is done through a plain configuration write port. The port works only while no run is in progress. A one-cycle start pulse then begins a run. The stimulus leaves through a valid/ready stream. The word on `stim_data` is offered with `stim_valid` high and is consumed on any rising edge where `stim_ready` is also high. While `stim_ready` is low, the offered word stays put. The sink may stall for any number of cycles, and a stall never adds to the count. The count and the completion flag are plain status outputs.

Top module: `pattern_order_seq`

## Requirements
- R1: After reset, `stim_valid` is 0, `done` is 0 and `total` is 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` into bank word `cfg_addr` when `cfg_sel` is 0. It stores `cfg_wdata[3:0]` into order slot `cfg_addr` when `cfg_sel` is 1. Addresses 10 to 15 are ignored, and every write is ignored while `stim_valid` is high.
- R3: A `start` pulse while `stim_valid` is low begins a run. On the next cycle `stim_valid` is 1, `total` is 0 and `done` is 0. A `start` pulse while `stim_valid` is high has no effect.
- R4: While `stim_valid` is 1 and `stim_ready` is 0, the next cycle keeps `stim_valid` at 1 and `stim_data` unchanged.
- R5: The k-th word accepted in a run (k counted from 0) is bank word number `order[k]`. The first accepted word adds 0 to `total`. Every later accepted word adds the count of bits in which it differs from the word accepted before it. The new `total` is visible the cycle after the handshake.
- R6: With the ten reference words loaded and the order 0,1,...,9, a run ends with `total` = 128.
- R7: With the same words and the order 2,8,1,4,6,3,0,9,7,5, a run ends with `total` = 77.
- R8: The cycle after the tenth accepted word, `stim_valid` is 0 and `done` is 1. `done` and `total` then hold until the next accepted `start`, which clears both.
- R9: An order slot that holds an index from 10 to 15 presents the all-zero word.
- R10: Playing the same bank word twice in a row adds 0. As a result, the 5-bit words 00011,00000,11111,00111 cost 9 in that order and 5 in the order 00000,00011,00111,11111, with the last word repeated to fill the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 bank word, 1 order slot |
| cfg_addr | input | 4 | Bank word or order slot number |
| cfg_wdata | input | 32 | Write data |
| start | input | 1 | Begin a run (single-cycle pulse) |
| stim_data | output | 32 | Offered test word |
| stim_valid | output | 1 | Offered word is valid; high for the whole run |
| stim_ready | input | 1 | Sink accepts the offered word |
| total | output | 10 | Running transition count |
| done | output | 1 | Run complete; held until next start |

## Verification
The case that is hardest to reach from the ports is a stall that lands on the very first word or on the last word of a run. Covering both needs the ready pattern to hit many alignments. The bench therefore drives `stim_ready` from a free-running shift-register pattern across several runs of different orders. This places stalls at varied positions relative to `start` and to the final handshake. Writes and start pulses are also injected in the middle of a run, and a later run then shows that the bank and the count were left untouched.

// File: rtl/pos_pkg.sv
package pos_pkg;
  localparam int unsigned POS_VEC_W   = 32;
  localparam int unsigned POS_NUM_VEC = 10;
  localparam int unsigned POS_SEQ_LEN = 10;
  localparam int unsigned POS_ADDR_W  = 4;
  localparam int unsigned POS_TOT_W   = 10;

  typedef enum logic {
    CFG_VECTOR = 1'b0,
    CFG_ORDER  = 1'b1
  } cfg_target_e;
endpackage

// File: rtl/pos_vec_store.sv
module pos_vec_store #(
  parameter int unsigned VEC_W   = 32,
  parameter int unsigned NUM_VEC = 10,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_VEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [VEC_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [VEC_W-1:0]  rd_data
);
  logic [VEC_W-1:0] bank_q [NUM_VEC];

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
        bank_q[g] <= wr_data;
      end
    end
  end

  // Indices past the last word read as all zero.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = bank_q[i];
    end
  end
endmodule

// File: rtl/pos_order_table.sv
module pos_order_table #(
  parameter int unsigned SEQ_LEN = 10,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned POS_W  = $clog2(SEQ_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [POS_W-1:0]  rd_pos,
  output logic [IDX_W-1:0]  rd_idx
);
  logic [IDX_W-1:0] slot_q [SEQ_LEN];

  for (genvar g = 0; g < SEQ_LEN; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= IDX_W'(g);
      end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
        slot_q[g] <= wr_idx;
      end
    end
  end

  always_comb begin
    rd_idx = '0;
    for (int i = 0; i < SEQ_LEN; i++) begin
      if (rd_pos == POS_W'(i)) rd_idx = slot_q[i];
    end
  end
endmodule

// File: rtl/pos_popcount.sv
module pos_popcount #(
  parameter int unsigned W     = 32,
  localparam int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     bits,
  output logic [CNT_W-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CNT_W'(bits[i]);
    end
  end
endmodule

// File: rtl/pattern_order_seq.sv
module pattern_order_seq
  import pos_pkg::*;
#(
  parameter int unsigned VEC_W   = POS_VEC_W,
  parameter int unsigned NUM_VEC = POS_NUM_VEC,
  parameter int unsigned SEQ_LEN = POS_SEQ_LEN,
  parameter int unsigned ADDR_W  = POS_ADDR_W,
  parameter int unsigned TOT_W   = POS_TOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [VEC_W-1:0]  cfg_wdata,
  input  logic              start,
  output logic [VEC_W-1:0]  stim_data,
  output logic              stim_valid,
  input  logic              stim_ready,
  output logic [TOT_W-1:0]  total,
  output logic              done
);
  localparam int unsigned IDX_W = $clog2(NUM_VEC);
  localparam int unsigned POS_W = $clog2(SEQ_LEN);
  localparam int unsigned CNT_W = $clog2(VEC_W + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SEQ_LEN - 1);

  logic              busy_q, done_q, has_prev_q;
  logic [POS_W-1:0]  pos_q;
  logic [VEC_W-1:0]  prev_q;
  logic [TOT_W-1:0]  total_q;
  logic [IDX_W-1:0]  cur_idx;
  logic [VEC_W-1:0]  cur_vec;
  logic [CNT_W-1:0]  step_cost;
  logic              cfg_ok, vec_we, ord_we, fire, start_ok;

  assign cfg_ok   = cfg_we && !busy_q;
  assign vec_we   = cfg_ok && (cfg_target_e'(cfg_sel) == CFG_VECTOR);
  assign ord_we   = cfg_ok && (cfg_target_e'(cfg_sel) == CFG_ORDER);
  assign fire     = busy_q && stim_ready;
  assign start_ok = start && !busy_q;

  pos_order_table #(
    .SEQ_LEN(SEQ_LEN), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_order (
    .clk(clk), .rst_n(rst_n), .wr_en(ord_we), .wr_addr(cfg_addr),
    .wr_idx(cfg_wdata[IDX_W-1:0]), .rd_pos(pos_q), .rd_idx(cur_idx)
  );

  pos_vec_store #(
    .VEC_W(VEC_W), .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(vec_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .rd_idx(cur_idx), .rd_data(cur_vec)
  );

  pos_popcount #(.W(VEC_W)) u_pop (
    .bits(cur_vec ^ prev_q), .ones(step_cost)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      has_prev_q <= 1'b0;
      pos_q      <= '0;
      prev_q     <= '0;
      total_q    <= '0;
    end else if (start_ok) begin
      busy_q     <= 1'b1;
      done_q     <= 1'b0;
      has_prev_q <= 1'b0;
      pos_q      <= '0;
      total_q    <= '0;
    end else if (fire) begin
      prev_q     <= cur_vec;
      has_prev_q <= 1'b1;
      if (has_prev_q) total_q <= total_q + TOT_W'(step_cost);
      if (pos_q == LAST_POS) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign stim_data  = cur_vec;
  assign stim_valid = busy_q;
  assign total      = total_q;
  assign done       = done_q;

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stim_valid) |=> (stim_valid && total == '0 && !done));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_valid && !stim_ready) |=> (stim_valid && $stable(stim_data)));

  assert_first_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !has_prev_q) |=> (total == $past(total)));

  assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !start) |=> ((total >= $past(total)) &&
                          ((total - $past(total)) <= TOT_W'(VEC_W))));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    total <= TOT_W'((SEQ_LEN - 1) * VEC_W));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stim_valid);

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(total)));

  if (NUM_VEC < (1 << IDX_W)) begin : g_oob_chk
    assert_oob_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stim_valid && cur_idx >= IDX_W'(NUM_VEC)) |-> (stim_data == '0));
  end
endmodule

// File: tb/pattern_order_seq_bench.sv
module pattern_order_seq_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic [31:0] stim_data;
  logic        stim_valid;
  logic        stim_ready = 1'b1;
  logic [9:0]  total;
  logic        done;

  pattern_order_seq u_pattern_order_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .start(start),
    .stim_data(stim_data), .stim_valid(stim_valid), .stim_ready(stim_ready),
    .total(total), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  logic [31:0] mbank [10];
  int          mord  [10];
  logic [31:0] expq  [$];
  int          exp_total;
  bit          exp_first;
  bit          ready_mode;
  logic [7:0]  lfsr = 8'hA5;
  bit          hold_pend;
  logic [31:0] hold_data;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Monitor and scoreboard: sample away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (ready_mode) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        stim_ready = lfsr[0] | lfsr[2];
      end else begin
        stim_ready = 1'b1;
      end
      if (hold_pend) begin
        check(stim_valid && stim_data == hold_data, "R4", "held word",
              stim_data, hold_data);
      end
      if (stim_valid) begin
        check(total == exp_total[9:0], "R5", "running total", total, exp_total);
      end
      hold_pend = stim_valid && !stim_ready;
      hold_data = stim_data;
      if (stim_valid && stim_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R5", "unexpected word", stim_data, 0);
        end else begin
          logic [31:0] e;
          e = expq.pop_front();
          check(stim_data == e, "R5", "accepted word", stim_data, e);
          if (!exp_first) exp_total += $countones(e ^ hold_prev);
          exp_first = 1'b0;
          hold_prev = e;
        end
      end
    end
  end
  logic [31:0] hold_prev;

  task automatic cfg_write(input bit sel, input int addr, input logic [31:0] d,
                           input bit effective);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr[3:0]; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (effective && addr < 10) begin
      if (sel) mord[addr] = int'(d[3:0]);
      else     mbank[addr] = d;
    end
  endtask

  task automatic load_order(input int o[10]);
    for (int i = 0; i < 10; i++) cfg_write(1'b1, i, 32'(o[i]), 1'b1);
  endtask

  function automatic logic [31:0] word_at(input int idx);
    return (idx < 10) ? mbank[idx] : 32'h0;
  endfunction

  // Driver: push the expected words, start, inject mid-run noise, wait.
  task automatic run_seq(input string req, input int stated, input bit noise);
    int model;
    model = 0;
    for (int k = 0; k < 10; k++) begin
      expq.push_back(word_at(mord[k]));
      if (k > 0) model += $countones(word_at(mord[k]) ^ word_at(mord[k-1]));
    end
    exp_total = 0;
    exp_first = 1'b1;
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(stim_valid && !done && total == 0, "R3", "run begins",
          {stim_valid, done, total}, {1'b1, 1'b0, 10'd0});
    if (noise) begin
      cfg_write(1'b0, 0, 32'h0, 1'b0);          // R2: ignored while busy
      cfg_write(1'b1, 1, 32'h5, 1'b0);
      @(posedge clk); #1; start = 1'b1;        // R3: ignored while busy
      @(posedge clk); #1; start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(!stim_valid, "R8", "valid low at done", stim_valid, 0);
    check(total == model[9:0], req, "final total vs model", total, model);
    if (stated >= 0)
      check(total == stated[9:0], req, "final total vs stated", total, stated);
    check(expq.size() == 0, "R5", "all words consumed", expq.size(), 0);
    repeat (3) @(negedge clk);
    check(done && total == model[9:0] && !stim_valid, "R8", "done holds",
          {done, total}, {1'b1, model[9:0]});
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        check(1'b0, "R8", "watchdog expired", cyc, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int nat[10] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9};
    int opt[10] = '{2, 8, 1, 4, 6, 3, 0, 9, 7, 5};
    int oob[10] = '{3, 12, 15, 10, 5, 5, 11, 0, 14, 2};
    int exa[10] = '{0, 1, 2, 3, 3, 3, 3, 3, 3, 3};
    int exb[10] = '{1, 0, 3, 2, 2, 2, 2, 2, 2, 2};
    for (int i = 0; i < 10; i++) begin mbank[i] = '0; mord[i] = i; end
    ready_mode = 1'b0;
    hold_pend = 1'b0;
    hold_prev = '0;
    exp_total = 0;
    exp_first = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(!stim_valid && !done && total == 0, "R1", "reset state",
          {stim_valid, done, total}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!stim_valid && !done && total == 0, "R1", "state after release",
          {stim_valid, done, total}, 0);

    cfg_write(1'b0, 0, 32'hDB6DDFFF, 1'b1);
    cfg_write(1'b0, 1, 32'h6DB6FFFF, 1'b1);
    cfg_write(1'b0, 2, 32'h00002FFF, 1'b1);
    cfg_write(1'b0, 3, 32'hB6DBDFFF, 1'b1);
    cfg_write(1'b0, 4, 32'hFFFFD555, 1'b1);
    cfg_write(1'b0, 5, 32'hFFFF6AAA, 1'b1);
    cfg_write(1'b0, 6, 32'h3FFDD555, 1'b1);
    cfg_write(1'b0, 7, 32'h3FFDAAAB, 1'b1);
    cfg_write(1'b0, 8, 32'hEDB62FFF, 1'b1);
    cfg_write(1'b0, 9, 32'hDB6CAAAA, 1'b1);
    cfg_write(1'b0, 12, 32'h12345678, 1'b0);  // R2: out-of-range address
    cfg_write(1'b1, 13, 32'h7, 1'b0);
    load_order(nat);

    run_seq("R6", 128, 1'b0);                 // R6 natural order, no stalls
    ready_mode = 1'b1;
    run_seq("R6", 128, 1'b0);                 // R6 with back-pressure (R4)
    load_order(opt);
    run_seq("R7", 77, 1'b1);                  // R7 plus R2/R3 mid-run noise
    run_seq("R2", 77, 1'b0);                  // R2: bank unchanged by noise
    load_order(oob);
    run_seq("R9", -1, 1'b0);                  // R9 out-of-range indices

    cfg_write(1'b0, 0, 32'h00000003, 1'b1);
    cfg_write(1'b0, 1, 32'h00000000, 1'b1);
    cfg_write(1'b0, 2, 32'h0000001F, 1'b1);
    cfg_write(1'b0, 3, 32'h00000007, 1'b1);
    load_order(exa);
    run_seq("R10", 9, 1'b0);                  // R10 unsorted example
    load_order(exb);
    run_seq("R10", 5, 1'b0);                  // R10 sorted example

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule